// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus of a 16-bit processor whose address and data share one set of lines. The core presents one request at a time: a word address, two byte enables, read or write, memory or I/O, a two-bit segment code, the interrupt-enable flag and the write data. The sequencer accepts the request and steps through the T-states T1, T2, T3, any number of wait states (TW) and T4. It drives the shared lines with separate value and enable outputs, so the tri-state buffers can sit outside the block. It also produces the address latch pulse, the read and write strobes, the data enable, the direction select and the memory/IO select.

The request handshake is a single-cycle `ack_o` in the cycle the request is taken. `done_o` is high during T4, and read data is returned on `rdata_o` in that same cycle. A new request can be taken in T4, which gives back-to-back cycles with no idle state in between. An external master can ask for the bus with `hold_i`. The block then raises `hlda_o` and floats every bus and control line except the address latch enable. It drives them again only when it starts its next cycle.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle. `ale_o`=0, `rd_n_o`=`wr_n_o`=`den_n_o`=1, `ad_oe_o`=0, `bus_oe_o`=1, `hlda_o`=0, `ack_o`=`done_o`=0, `bhe_n_o`=1 and `as_o`=0.
- R2: T1 lasts one cycle, with `ale_o`=1 only in that cycle and `ad_oe_o`=1. In T1, `ad_o` carries `{addr_i[15:1], ~be_i[0]}`, so bit 0 is low when the lower byte (be bit 0) moves. `bhe_n_o` is the inverse of be bit 1 (the upper byte) in T1 and is high in every other state. `as_o` carries `addr_i[19:16]` for memory and 0 for I/O.
- R3: In T2, T3, TW and T4, `as_o` carries status: bit 3 is 0 (this master owns the bus), bit 2 is the interrupt-enable flag, and bits 1:0 are the segment code (00 extra, 01 stack, 10 code, 11 data).
- R4: In a read, `rd_n_o` is low in T2, T3 and TW, and `ad_oe_o` is 0 from T2 through T4. `ad_i` is captured on the clock edge that leaves T3 or TW with `ready_i` high, and it is presented on `rdata_o` during T4.
- R5: In a write, `wr_n_o` is low in T2, T3 and TW, and `ad_o` drives the write data with `ad_oe_o`=1 from T2 through T4. `dtr_o` is 1 for a write and 0 for a read. Read and write strobes are never low together.
- R6: `den_n_o` goes low at the start of T2 and returns high at the falling clock edge in the middle of T4.
- R7: `mio_o` (1 = memory, 0 = I/O) takes the new request's value in the cycle the request is accepted and holds it through the final T4.
- R8: T3 is followed by one TW for each cycle in which `ready_i` is sampled low, and T4 follows the first cycle in which it is sampled high.
- R9: `ack_o` is high in the cycle a request is accepted, which is an idle cycle or T4 with `req_i`=1 and `hold_i`=0. The next cycle is T1. `done_o` is high for exactly the T4 cycle.
- R10: `hold_i` seen in an idle cycle or in T4 makes the next cycle a hold state. In the hold state `hlda_o`=1 and `bus_oe_o`=`ad_oe_o`=0, while `ale_o` stays driven low. When `hold_i` falls, `hlda_o` drops one cycle later, and `bus_oe_o` stays 0 until the T1 of the next accepted request.
- R11: While `hold_i` is high no request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request valid |
| addr_i | input | 19 | Address bits 19:1 |
| be_i | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| wr_i | input | 1 | 1 write, 0 read |
| mem_i | input | 1 | 1 memory, 0 I/O |
| seg_i | input | 2 | Segment code for status |
| ie_i | input | 1 | Interrupt-enable flag for status |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Request accepted |
| done_o | output | 1 | High in T4 |
| rdata_o | output | 16 | Read data, valid in T4 |
| ready_i | input | 1 | Device ready, low inserts wait states |
| hold_i | input | 1 | Bus request from another master |
| hlda_o | output | 1 | Bus released |
| ad_i | input | 16 | Shared lines, input side |
| ad_o | output | 16 | Shared lines, output value |
| ad_oe_o | output | 1 | Shared lines drive enable |
| as_o | output | 4 | Upper address / status lines |
| bus_oe_o | output | 1 | Drive enable for status and control lines |
| ale_o | output | 1 | Address latch enable |
| bhe_n_o | output | 1 | Upper byte enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| den_n_o | output | 1 | Data enable, active low |
| dtr_o | output | 1 | Direction, 1 transmit |
| mio_o | output | 1 | 1 memory, 0 I/O |

## Verification
The hardest situations to reach are where a bus cycle meets a change of ownership or a second request: a request arriving in T4, and `hold_i` rising in T4 or while a request is already waiting. The stimulus presents the next request in the exact T4 cycle of a write with wait states. It then raises hold in the T4 of the following read. After that it keeps `req_i` high through a whole hold episode, so the bench can confirm that acknowledgement is withheld and that the lines stay floated until the delayed cycle's T1. The falling-edge release of the data enable is observed by sampling every cycle in both clock halves.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HI_W   = ADDR_W - DATA_W;
  localparam int unsigned SEG_W  = 2;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic [2:0] {
    TS_IDLE, TS_T1, TS_T2, TS_T3, TS_TW, TS_T4, TS_HOLD
  } tstate_e;

  typedef struct packed {
    logic [ADDR_W-1:1] addr;
    logic [BE_W-1:0]   be;
    logic              wr;
    logic              mem;
    logic [SEG_W-1:0]  seg;
    logic              ie;
    logic [DATA_W-1:0] wdata;
  } breq_t;
endpackage

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
  import mux_bus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ready_i,
  input  logic    hold_i,
  output tstate_e state_o,
  output logic    accept_o,
  output logic    own_o,
  output logic    latch_rd_o
);
  tstate_e state_q, state_d;
  logic    own_q;
  logic    slot;

  assign slot       = (state_q == TS_IDLE) || (state_q == TS_T4);
  assign accept_o   = slot && req_i && !hold_i;
  assign latch_rd_o = ((state_q == TS_T3) || (state_q == TS_TW)) && ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE, TS_T4: begin
        if (hold_i)       state_d = TS_HOLD;
        else if (req_i)   state_d = TS_T1;
        else              state_d = TS_IDLE;
      end
      TS_T1:            state_d = TS_T2;
      TS_T2:            state_d = TS_T3;
      TS_T3, TS_TW:     state_d = ready_i ? TS_T4 : TS_TW;
      TS_HOLD:          state_d = hold_i ? TS_HOLD : TS_IDLE;
      default:          state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      own_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_d == TS_HOLD) own_q <= 1'b0;
      else if (accept_o)      own_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign own_o   = own_q;
endmodule

// File: rtl/mux_bus_drive.sv
module mux_bus_drive
  import mux_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  breq_t             rq_i,
  input  logic              accept_i,
  input  logic              mem_in_i,
  input  logic              own_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   as_o,
  output logic              bus_oe_o,
  output logic              ale_o,
  output logic              bhe_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              den_n_o,
  output logic              dtr_o,
  output logic              mio_o
);
  logic mid, dat, t1, den_late_q;

  assign t1  = (state_i == TS_T1);
  assign mid = (state_i == TS_T2) || (state_i == TS_T3) || (state_i == TS_TW);
  assign dat = mid || (state_i == TS_T4);

  // data enable stays on until the falling edge inside T4
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) den_late_q <= 1'b0;
    else         den_late_q <= mid;
  end

  assign ale_o    = t1;
  assign rd_n_o   = !(mid && !rq_i.wr);
  assign wr_n_o   = !(mid && rq_i.wr);
  assign den_n_o  = !(mid || ((state_i == TS_T4) && den_late_q));
  assign ad_oe_o  = t1 || (dat && rq_i.wr);
  assign bhe_n_o  = !(t1 && rq_i.be[BE_W-1]);
  assign bus_oe_o = own_i;
  assign dtr_o    = rq_i.wr;
  assign mio_o    = accept_i ? mem_in_i : rq_i.mem;

  always_comb begin
    ad_o = '0;
    if (t1)                ad_o = {rq_i.addr[DATA_W-1:1], ~rq_i.be[0]};
    else if (dat && rq_i.wr) ad_o = rq_i.wdata;
  end

  always_comb begin
    as_o = '0;
    if (t1)       as_o = rq_i.mem ? rq_i.addr[ADDR_W-1:DATA_W] : '0;
    else if (dat) as_o = {{(HI_W-SEG_W-1){1'b0}}, rq_i.ie, rq_i.seg};
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              wr_i,
  input  logic              mem_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              ie_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   as_o,
  output logic              bus_oe_o,
  output logic              ale_o,
  output logic              bhe_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              den_n_o,
  output logic              dtr_o,
  output logic              mio_o
);
  tstate_e           state;
  logic              accept, own, latch_rd;
  breq_t             rq_q;
  logic [DATA_W-1:0] rdata_q;

  mux_bus_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ready_i    (ready_i),
    .hold_i     (hold_i),
    .state_o    (state),
    .accept_o   (accept),
    .own_o      (own),
    .latch_rd_o (latch_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (accept)   rq_q <= '{addr: addr_i, be: be_i, wr: wr_i, mem: mem_i,
                              seg: seg_i, ie: ie_i, wdata: wdata_i};
      if (latch_rd) rdata_q <= ad_i;
    end
  end

  mux_bus_drive u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .rq_i     (rq_q),
    .accept_i (accept),
    .mem_in_i (mem_i),
    .own_i    (own),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .as_o     (as_o),
    .bus_oe_o (bus_oe_o),
    .ale_o    (ale_o),
    .bhe_n_o  (bhe_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .den_n_o  (den_n_o),
    .dtr_o    (dtr_o),
    .mio_o    (mio_o)
  );

  assign ack_o   = accept;
  assign done_o  = (state == TS_T4);
  assign hlda_o  = (state == TS_HOLD);
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_i,
  input logic hold_i,
  input logic ack_o,
  input logic done_o,
  input logic hlda_o,
  input logic ad_oe_o,
  input logic bus_oe_o,
  input logic ale_o,
  input logic rd_n_o,
  input logic wr_n_o
);
  a_r2_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r2_ale_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && bus_oe_o));
  a_r4_rd_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);
  a_r5_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  a_r8_ready_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(done_o)) |-> $past(ready_i));
  a_r9_ack_to_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> ale_o);
  a_r10_hold_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!bus_oe_o && !ad_oe_o));
  a_r10_hlda_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(hold_i));
  a_r11_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !ack_o);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_i  (ready_i),
  .hold_i   (hold_i),
  .ack_o    (ack_o),
  .done_o   (done_o),
  .hlda_o   (hlda_o),
  .ad_oe_o  (ad_oe_o),
  .bus_oe_o (bus_oe_o),
  .ale_o    (ale_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  localparam int SI = 0, S1 = 1, S2 = 2, S3 = 3, SW = 4, S4 = 5, SH = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, wr_i = 1'b0, mem_i = 1'b0, ie_i = 1'b0;
  logic ready_i = 1'b1, hold_i = 1'b0;
  logic [19:1] addr_i = '0;
  logic [1:0]  be_i = '0, seg_i = '0;
  logic [15:0] wdata_i = '0, ad_i = '0;
  logic ack_o, done_o, hlda_o, ad_oe_o, bus_oe_o, ale_o, bhe_n_o;
  logic rd_n_o, wr_n_o, den_n_o, dtr_o, mio_o;
  logic [15:0] rdata_o, ad_o;
  logic [3:0]  as_o;

  always #4 clk = ~clk;

  mux_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .be_i(be_i),
    .wr_i(wr_i), .mem_i(mem_i), .seg_i(seg_i), .ie_i(ie_i), .wdata_i(wdata_i),
    .ack_o(ack_o), .done_o(done_o), .rdata_o(rdata_o), .ready_i(ready_i),
    .hold_i(hold_i), .hlda_o(hlda_o), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .as_o(as_o), .bus_oe_o(bus_oe_o), .ale_o(ale_o), .bhe_n_o(bhe_n_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .den_n_o(den_n_o), .dtr_o(dtr_o), .mio_o(mio_o)
  );

  typedef struct {
    logic [19:1] addr; logic [1:0] be; bit wr; bit mem;
    logic [15:0] wdata; logic [1:0] seg; bit ie; int nwait; logic [15:0] rdval;
  } txn_t;

  typedef struct { string tag; logic [47:0] v; logic [47:0] m; } item_t;

  item_t q[$];
  txn_t  cur = '{default: 0};
  bit    own_m = 1'b1;
  int    checks = 0, errors = 0;

  function automatic logic [47:0] snap();
    return {rdata_o, ale_o, rd_n_o, wr_n_o, den_n_o, ad_oe_o, bus_oe_o, hlda_o,
            ack_o, done_o, mio_o, dtr_o, bhe_n_o, as_o, ad_o};
  endfunction

  // expected pin table per T-state, both clock halves
  function automatic void expect_st(string tag, int s, bit ack, bit acc_mem);
    for (int h = 0; h < 2; h++) begin
      logic [47:0] v = '0, m = '1;
      bit mid = (s == S2) || (s == S3) || (s == SW);
      bit dat = mid || (s == S4);
      v[47:32] = cur.rdval;    m[47:32] = {16{(s == S4) && !cur.wr}};
      v[31] = (s == S1);
      v[30] = !(mid && !cur.wr);
      v[29] = !(mid && cur.wr);
      v[28] = !(mid || ((s == S4) && (h == 0)));
      v[27] = (s == S1) || (dat && cur.wr);
      v[26] = own_m;
      v[25] = (s == SH);
      v[24] = ack;
      v[23] = (s == S4);
      v[22] = ack ? acc_mem : cur.mem;
      m[22] = own_m && !((s == SI) && !ack) && (s != SH);
      v[21] = cur.wr;          m[21] = own_m && (s != SI) && (s != SH);
      v[20] = (s == S1) ? ~cur.be[1] : 1'b1;
      v[19:16] = (s == S1) ? (cur.mem ? cur.addr[19:16] : 4'h0)
               : dat ? {1'b0, cur.ie, cur.seg} : 4'h0;
      m[19:16] = {4{own_m}};
      v[15:0] = (s == S1) ? {cur.addr[15:1], ~cur.be[0]} : cur.wdata;
      m[15:0] = {16{(s == S1) || (dat && cur.wr)}};
      q.push_back('{tag, v, m});
    end
  endfunction

  task automatic compare();
    item_t it;
    logic [47:0] a;
    if (q.size() == 0) return;
    it = q.pop_front();
    a = snap();
    checks++;
    if (((a ^ it.v) & it.m) !== 48'h0) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h mask=%h", it.tag, $time, a, it.v, it.m);
    end
  endtask

  always @(posedge clk) begin #2; compare(); end
  always @(negedge clk) begin #2; compare(); end

  task automatic tick(bit req, bit rdy, bit hld, logic [15:0] adin);
    @(posedge clk); #1;
    req_i = req; ready_i = rdy; hold_i = hld; ad_i = adin;
  endtask

  task automatic set_req(txn_t t);
    addr_i = t.addr; be_i = t.be; wr_i = t.wr; mem_i = t.mem;
    wdata_i = t.wdata; seg_i = t.seg; ie_i = t.ie;
  endtask

  task automatic scramble();
    addr_i = ~addr_i; be_i = ~be_i; wr_i = ~wr_i; wdata_i = ~wdata_i;
    seg_i = ~seg_i; ie_i = ~ie_i;
  endtask

  // T1..T4; chain presents nx in T4, hend raises hold in T4
  task automatic body(bit chain, txn_t nx, bit hend);
    own_m = 1'b1;
    tick(0, 1, 0, ~cur.rdval); scramble(); expect_st("R2", S1, 0, 0);
    tick(0, 1, 0, ~cur.rdval); expect_st(cur.wr ? "R5" : "R4", S2, 0, 0);
    tick(0, cur.nwait == 0, 0, cur.rdval); expect_st("R3", S3, 0, 0);
    for (int k = 1; k <= cur.nwait; k++) begin
      tick(0, k == cur.nwait, 0, cur.rdval); expect_st("R8", SW, 0, 0);
    end
    if (chain) begin
      tick(1, 1, 0, ~cur.rdval); set_req(nx); expect_st("R9", S4, 1, nx.mem);
      cur = nx;
    end else begin
      tick(0, 1, hend, ~cur.rdval); expect_st("R6", S4, 0, 0);
    end
  endtask

  task automatic start(txn_t t);
    tick(1, 1, 0, 16'h0); set_req(t); expect_st("R7", SI, 1, t.mem);
    cur = t;
  endtask

  task automatic idle(string tag);
    tick(0, 1, 0, 16'h0); expect_st(tag, SI, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    txn_t t1, t2, t3, t4, t5, none;
    none = '{default: 0};
    t1 = '{addr: 19'h5A3C1, be: 2'b11, wr: 0, mem: 1, wdata: 16'h0, seg: 2'b10, ie: 1, nwait: 0, rdval: 16'hC3A5};
    t2 = '{addr: 19'h7FFFF, be: 2'b01, wr: 1, mem: 0, wdata: 16'h1234, seg: 2'b00, ie: 0, nwait: 2, rdval: 16'h0};
    t3 = '{addr: 19'h12345, be: 2'b10, wr: 1, mem: 1, wdata: 16'hBEEF, seg: 2'b01, ie: 1, nwait: 1, rdval: 16'h0};
    t4 = '{addr: 19'h40002, be: 2'b11, wr: 0, mem: 1, wdata: 16'h0, seg: 2'b11, ie: 0, nwait: 0, rdval: 16'h5A0F};
    t5 = '{addr: 19'h00AAA, be: 2'b01, wr: 0, mem: 0, wdata: 16'h0, seg: 2'b01, ie: 1, nwait: 3, rdval: 16'h9669};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    idle("R1"); idle("R1");
    start(t1); body(0, none, 0); idle("R9");
    start(t2); body(0, none, 0); idle("R9");
    start(t3); body(1, t4, 0); body(0, none, 1);
    own_m = 1'b0;
    tick(0, 1, 1, 16'h0); expect_st("R10", SH, 0, 0);
    tick(0, 1, 0, 16'h0); expect_st("R10", SH, 0, 0);
    idle("R10");
    tick(1, 1, 1, 16'h0); set_req(t5); expect_st("R11", SI, 0, 0);
    tick(1, 1, 1, 16'h0); expect_st("R11", SH, 0, 0);
    tick(1, 1, 0, 16'h0); expect_st("R10", SH, 0, 0);
    start(t5); body(0, none, 0);
    idle("R9"); idle("R1");
    @(posedge clk); #6;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule